// File: doc/BRIEF.md
# Dual-Mode Registered Bus Driver

An 18-bit data path that forwards a parallel input word to a three-state output bus. Each bit has a single storage element that works in one of two modes. A shared active-low pass control selects the mode. While pass is low, the output follows the input word with no clock involved. While pass is high, the word is captured on each rising edge of a capture clock and held between edges.

A separate active-low output enable decides whether the bus is driven or left floating. The enable acts only on the output stage and never on the stored word. For flows that cannot build internal three-state nets, the block also presents the resolved value and a per-bit drive enable as plain outputs. An active-low asynchronous reset clears the stored word, so that every run starts from a known state.

Top module: `dual_mode_bus_driver`

## Requirements
- R1: While rst_ni is low, the stored word is all zeros, so bus_val_o reads 0 whenever pass_ni is high.
- R2: While pass_ni is low, bus_val_o equals d_i at all times, with no clock edge needed.
- R3: While pass_ni is high, a rising edge of clk_i loads d_i, and bus_val_o then shows the loaded word.
- R4: While pass_ni is high and clk_i holds steady, either low or high, changes on d_i leave bus_val_o unchanged.
- R5: While out_en_ni is high, every bit of bus_drv_o is 0 and bus_o floats. While it is low, every bit of bus_drv_o is 1 and bus_o equals bus_val_o.
- R6: Toggling out_en_ni never changes the stored word. Captures made while the bus is disabled still take effect, and on re-enable the bus shows the word held at that point.
- R7: If pass_ni rises while clk_i is already high, the output keeps the last word that passed through in pass mode, until the next rising edge of clk_i.
- R8: A rising edge of clk_i while pass_ni is low has no visible effect: bus_val_o keeps following d_i.
- R9: All 18 bits behave identically and independently under the shared controls. Bit i of d_i appears only on bit i of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock; its rising edge loads the word in register mode |
| rst_ni | input | 1 | Active-low asynchronous clear of the stored word |
| pass_ni | input | 1 | Active-low mode select: low = pass-through, high = registered |
| out_en_ni | input | 1 | Active-low output enable for the bus |
| d_i | input | 18 | Input data word |
| bus_o | output | 18 | Three-state output bus |
| bus_val_o | output | 18 | Resolved output value, independent of the enable |
| bus_drv_o | output | 18 | Per-bit drive enable (1 = driven) |

## Verification
The pass mode is driven with all-ones, all-zeros and two alternating-bit words. These patterns show whether the output truly follows the input rather than sticking at a stored value. The registered mode is driven with distinct words before and after a clock edge, both with the clock held low and with it held high. This separates capture from holding, and shows whether a steady clock in either phase lets input changes through. The mode switches are tested with the clock high at the moment pass is released, and with a clock edge during pass mode. These show whether the held word is the last word that passed through or a stale earlier capture. A walking-one sweep over the register path exposes any bit swap or bit crossover.

// File: rtl/regdrv_pkg.sv
package regdrv_pkg;
  parameter int unsigned BUS_W = 18;

  typedef enum logic {
    MODE_PASS = 1'b0,
    MODE_HOLD = 1'b1
  } mode_e;
endpackage

// File: rtl/regdrv_store.sv
module regdrv_store #(
  parameter int unsigned W = regdrv_pkg::BUS_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pass_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // loads on capture edge, and on the end of pass mode so the held word is continuous
  always_ff @(posedge clk_i or posedge pass_ni or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d_i;
  end

  assign q_o = q;

  // checker state: word and mode seen at the last capture edge
  logic [W-1:0] d_at_edge;
  logic         hold_at_edge;
  logic         live_at_edge;

  always_ff @(posedge clk_i) begin
    d_at_edge    <= d_i;
    hold_at_edge <= pass_ni;
    live_at_edge <= rst_ni;
  end

  // R3: a capture in register mode holds through the high phase
  p_capture_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (live_at_edge && hold_at_edge && pass_ni) |-> (q == d_at_edge));
endmodule

// File: rtl/regdrv_sel.sv
module regdrv_sel #(
  parameter int unsigned W = regdrv_pkg::BUS_W
) (
  input  logic         pass_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] q_i,
  output logic [W-1:0] val_o
);
  import regdrv_pkg::*;

  mode_e mode;
  assign mode = mode_e'(pass_ni);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (mode)
        MODE_PASS: val_o[i] = d_i[i];
        default:   val_o[i] = q_i[i];
      endcase
    end
  end
endmodule

// File: rtl/regdrv_drv.sv
module regdrv_drv #(
  parameter int unsigned W = regdrv_pkg::BUS_W
) (
  input  logic         out_en_ni,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] drv_o,
  output wire  [W-1:0] bus_o
);
  assign drv_o = {W{~out_en_ni}};

  for (genvar i = 0; i < W; i++) begin : g_pad
    assign bus_o[i] = drv_o[i] ? val_i[i] : 1'bz;
  end
endmodule

// File: rtl/dual_mode_bus_driver.sv
module dual_mode_bus_driver #(
  parameter int unsigned W = regdrv_pkg::BUS_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pass_ni,
  input  logic         out_en_ni,
  input  logic [W-1:0] d_i,
  output wire  [W-1:0] bus_o,
  output logic [W-1:0] bus_val_o,
  output logic [W-1:0] bus_drv_o
);
  logic [W-1:0] q;
  logic [W-1:0] val;

  regdrv_store #(.W(W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pass_ni (pass_ni),
    .d_i     (d_i),
    .q_o     (q)
  );

  regdrv_sel #(.W(W)) u_sel (
    .pass_ni (pass_ni),
    .d_i     (d_i),
    .q_i     (q),
    .val_o   (val)
  );

  regdrv_drv #(.W(W)) u_drv (
    .out_en_ni (out_en_ni),
    .val_i     (val),
    .drv_o     (bus_drv_o),
    .bus_o     (bus_o)
  );

  assign bus_val_o = val;

  p_bypass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pass_ni |-> (bus_val_o == d_i));

  p_hiz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_ni |-> (bus_drv_o == '0));

  p_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_ni |-> (bus_drv_o == '1));
endmodule

// File: tb/dual_mode_bus_driver_test.sv
module dual_mode_bus_driver_test;
  localparam int W = 18;

  logic         tck = 1'b0;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pass_n = 1'b1;
  logic         oe_n = 1'b0;
  logic [W-1:0] d = '0;
  wire  [W-1:0] bus;
  logic [W-1:0] bus_val;
  logic [W-1:0] bus_drv;

  int n_chk = 0;
  int n_fail = 0;

  always #4 tck = ~tck;  // 125 MHz bench clock

  dual_mode_bus_driver #(.W(W)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pass_ni   (pass_n),
    .out_en_ni (oe_n),
    .d_i       (d),
    .bus_o     (bus),
    .bus_val_o (bus_val),
    .bus_drv_o (bus_drv)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic pulse();
    clk = 1'b1; #4;
    clk = 1'b0; #4;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pass_n = 1'b1; oe_n = 1'b0; d = 18'h2AAAA;
    #10; settle();
    chk("R1 reset clears word", bus_val, 18'h0);
    chk("R5 enabled drive", bus_drv, '1);
    rst_n = 1'b1; settle();
    chk("R1 word stays zero after release", bus_val, 18'h0);
  endtask

  task automatic t_pass();
    pass_n = 1'b0;
    d = 18'h3FFFF; settle(); chk("R2 pass ones", bus_val, 18'h3FFFF);
    d = 18'h00000; settle(); chk("R2 pass zeros", bus_val, 18'h00000);
    d = 18'h2AAAA; settle(); chk("R2 pass alt a", bus_val, 18'h2AAAA);
    d = 18'h15555; settle(); chk("R2 pass alt b", bus_val, 18'h15555);
    chk("R5 bus equals value", bus, 18'h15555);
  endtask

  task automatic t_register();
    pass_n = 1'b1; settle();
    d = 18'h12345; settle(); pulse();
    chk("R3 capture", bus_val, 18'h12345);
    d = 18'h0ABCD; settle();
    chk("R4 hold clock low", bus_val, 18'h12345);
    clk = 1'b1; settle();
    chk("R3 capture on rise", bus_val, 18'h0ABCD);
    d = 18'h3C3C3; settle();
    chk("R4 hold clock high", bus_val, 18'h0ABCD);
    #3; clk = 1'b0; settle();
    chk("R4 hold after fall", bus_val, 18'h0ABCD);
  endtask

  task automatic t_oe();
    oe_n = 1'b1; settle();
    chk("R5 disabled drive", bus_drv, '0);
    chk("R6 disable keeps word", bus_val, 18'h0ABCD);
    d = 18'h11111; settle(); pulse();
    chk("R6 capture while disabled", bus_val, 18'h11111);
    oe_n = 1'b0; settle();
    chk("R6 re-enable shows word", bus, 18'h11111);
    oe_n = 1'b1; d = 18'h22222; settle();
    oe_n = 1'b0; settle();
    chk("R6 toggle no change", bus, 18'h11111);
    chk("R5 re-enabled drive", bus_drv, '1);
  endtask

  task automatic t_release_clk_high();
    pass_n = 1'b0; d = 18'h0F0F0; settle();
    clk = 1'b1; settle();
    d = 18'h2468A; settle();
    chk("R8 pass after edge", bus_val, 18'h2468A);
    pass_n = 1'b1; settle();
    chk("R7 hold last passed word", bus_val, 18'h2468A);
    d = 18'h13579; settle();
    chk("R7 ignore input clock high", bus_val, 18'h2468A);
    clk = 1'b0; settle();
    chk("R7 still held after fall", bus_val, 18'h2468A);
    #3; clk = 1'b1; settle();
    chk("R7 next rise captures", bus_val, 18'h13579);
    #3; clk = 1'b0; #4;
  endtask

  task automatic t_edge_in_pass();
    pass_n = 1'b0; d = 18'h30303; settle(); pulse();
    chk("R8 edge no visible effect", bus_val, 18'h30303);
    d = 18'h0C0C0; settle();
    chk("R8 still follows input", bus_val, 18'h0C0C0);
    pass_n = 1'b1; settle();
    d = 18'h3FFFF; settle();
    chk("R7 release clock low holds", bus_val, 18'h0C0C0);
  endtask

  task automatic t_bits();
    pass_n = 1'b1;
    for (int i = 0; i < W; i++) begin
      d = 18'(1) << i; settle(); pulse();
      chk($sformatf("R9 walking one bit %0d", i), bus_val, 18'(1) << i);
    end
    d = 18'h3FFFF ^ 18'h00001; settle(); pulse();
    chk("R9 walking zero lsb", bus, 18'h3FFFE);
  endtask

  initial begin
    #2;
    t_reset();
    t_pass();
    t_register();
    t_oe();
    t_release_clk_high();
    t_edge_in_pass();
    t_bits();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge tck);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule